// File: doc/BRIEF.md
# Fully Associative Translation Cache with Use and Modify Tracking

This block holds a small set of recent page translations and turns a virtual address into a physical address for 4 KiB pages. The low 12 bits of the address are the page offset and are passed through unchanged. The bits above them form the virtual page number. That number is compared against the tag of every valid slot at the same time. On a hit, the slot's physical page number replaces the upper bits, and the answer is available in the same cycle as the request. On a miss, the block returns a zero address and raises a miss flag. The requester then fetches the translation, loads it through the refill port and retries the access.

Every slot keeps a use bit and a modify bit. A hit sets the use bit, and a write hit also sets the modify bit, so the owner can tell which pages need write-back. A sweep command clears every use bit at once, which approximates least-recently-used tracking. The refill logic prefers to replace slots whose use bit is clear. A flush input empties the whole table.

Top module: `tlb_fa`

## Requirements
- R1: When `lk_valid` is high and a valid slot's tag equals `lk_vaddr[VA_W-1:12]`, `lk_hit` is 1 and `lk_miss` is 0 in the same cycle. `lk_paddr` then equals {slot PPN, `lk_vaddr[11:0]`}, and `lk_dirty` shows that slot's modify bit as it stood before the access.
- R2: When `lk_valid` is high and no valid slot matches, `lk_miss` is 1, `lk_hit` is 0, and `lk_paddr` and `lk_dirty` are 0. When `lk_valid` is low, `lk_hit` and `lk_miss` are both 0.
- R3: A hit sets the matching slot's use bit at the next clock edge.
- R4: A write hit (`lk_write`=1) sets the matching slot's modify bit at the next edge. A read hit leaves the modify bit unchanged.
- R5: A one-cycle pulse on `ref_clear` zeroes the use bit of every slot.
- R6: A refill picks its slot in this order: the slot already holding the same tag, else the lowest-index invalid slot, else the lowest-index slot whose use bit is 0, else slot 0.
- R7: A refill (`fill_en`) writes tag, PPN, use bit and modify bit into the chosen slot in one edge and marks the slot valid. A lookup is served from it in the following cycle.
- R8: A `flush` pulse invalidates every slot, so every lookup from the next cycle on misses.
- R9: A refill whose tag is already present overwrites that slot. No second copy is made, and no other slot is displaced.
- R10: After reset, every slot is invalid.
- R11: When inputs coincide, the following order applies. `flush` beats a refill in the same cycle. A refill beats the hit update of the same slot. A hit's use-bit set beats a simultaneous `ref_clear` for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released after two clocks |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a store access |
| lk_vaddr | input | VA_W | Virtual address |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent; refill and retry |
| lk_paddr | output | PA_W | Physical address, 0 on a miss |
| lk_dirty | output | 1 | Modify bit of the hit slot |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | VA_W-12 | Virtual page number to install |
| fill_ppn | input | PA_W-12 | Physical page number to install |
| fill_ref | input | 1 | Initial use bit |
| fill_dirty | input | 1 | Initial modify bit |
| ref_clear | input | 1 | Clear all use bits |
| flush | input | 1 | Invalidate all slots |

## Verification
The lookup outputs are combinational, so each lookup result is checked in the cycle the request is driven. Inputs change on the falling edge and outputs are sampled 2 ns later, before the next rising edge. Refill, flush, sweep, and the updates to the use and modify bits all land on the next rising edge, so their effect is checked with a lookup in the following cycle.

Use bits have no output of their own. They are observed one edge after the update, through which slot a later refill displaces. After a refill, a lookup shows which translation was lost. Reset is checked only after the two-clock release of the synchronised reset has passed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_OFS_W = 12;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input  logic [VPN_W-1:0]              key,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0]            vld,
  output logic [ENTRIES-1:0]            hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == key);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0] same_tag,
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] use_bits,
  output logic [ENTRIES-1:0] sel
);
  logic found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    if (|same_tag) begin
      sel   = same_tag;
      found = 1'b1;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !vld[i]) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !use_bits[i]) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    if (!found) sel[0] = 1'b1;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_dirty,
  input  logic              fill_en,
  input  logic [VA_W-13:0]  fill_vpn,
  input  logic [PA_W-13:0]  fill_ppn,
  input  logic              fill_ref,
  input  logic              fill_dirty,
  input  logic              ref_clear,
  input  logic              flush
);
  import tlb_pkg::*;
  localparam int VPN_W = VA_W - PAGE_OFS_W;
  localparam int PPN_W = PA_W - PAGE_OFS_W;

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [ENTRIES-1:0]            vld_q, vld_d, use_q, use_d, mod_q, mod_d;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q, ppn_d;
  logic [ENTRIES-1:0]            lk_match, fill_match, fill_sel;
  logic                          any_hit, upd_en;
  logic [PPN_W-1:0]              hit_ppn;
  logic                          hit_mod;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_cmp (
    .key(lk_vaddr[VA_W-1:PAGE_OFS_W]), .tags(tag_q), .vld(vld_q), .hit_vec(lk_match)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_cmp (
    .key(fill_vpn), .tags(tag_q), .vld(vld_q), .hit_vec(fill_match)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .same_tag(fill_match), .vld(vld_q), .use_bits(use_q), .sel(fill_sel)
  );

  always_comb begin
    hit_ppn = '0;
    hit_mod = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn = hit_ppn | (ppn_q[i] & {PPN_W{lk_match[i]}});
      hit_mod = hit_mod | (mod_q[i] & lk_match[i]);
    end
  end

  assign any_hit  = lk_valid && (|lk_match);
  assign lk_hit   = any_hit;
  assign lk_miss  = lk_valid && !(|lk_match);
  assign lk_paddr = any_hit ? {hit_ppn, lk_vaddr[PAGE_OFS_W-1:0]} : '0;
  assign lk_dirty = any_hit && hit_mod;

  always_comb begin
    vld_d = vld_q;
    use_d = use_q;
    mod_d = mod_q;
    tag_d = tag_q;
    ppn_d = ppn_q;
    if (ref_clear) use_d = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (any_hit && lk_match[i]) begin
        use_d[i] = 1'b1;
        if (lk_write) mod_d[i] = 1'b1;
      end
      if (fill_en && fill_sel[i]) begin
        vld_d[i] = 1'b1;
        tag_d[i] = fill_vpn;
        ppn_d[i] = fill_ppn;
        use_d[i] = fill_ref;
        mod_d[i] = fill_dirty;
      end
    end
    if (flush) vld_d = '0;
  end

  assign upd_en = flush || fill_en || ref_clear || any_hit;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vld_q <= '0;
      use_q <= '0;
      mod_q <= '0;
      tag_q <= '0;
      ppn_q <= '0;
    end else if (upd_en) begin
      vld_q <= vld_d;
      use_q <= use_d;
      mod_q <= mod_d;
      tag_q <= tag_d;
      ppn_q <= ppn_d;
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_write,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic [PA_W-1:0]    lk_paddr,
  input logic               fill_en,
  input logic               ref_clear,
  input logic               flush,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] use_bits,
  input logic [ENTRIES-1:0] mod_bits
);
  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss));
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0]));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_paddr == '0));
  assert_hit_marks_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !fill_en && !flush) |=> ((use_bits & $past(lk_match)) == $past(lk_match)));
  assert_store_marks_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !fill_en && !flush) |=> ((mod_bits & $past(lk_match)) == $past(lk_match)));
  assert_sweep_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clear && !lk_hit && !fill_en) |=> (use_bits == '0));
  assert_fill_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> (vld != '0));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));
  assert_no_duplicate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_sn), .lk_valid(lk_valid), .lk_write(lk_write),
  .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
  .fill_en(fill_en), .ref_clear(ref_clear), .flush(flush), .lk_match(lk_match),
  .vld(vld_q), .use_bits(use_q), .mod_bits(mod_q)
);

// File: tb/tlb_fa_tb_top.sv
module tlb_fa_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss, lk_dirty;
  logic [31:0] lk_paddr;
  logic        fill_en = 1'b0, fill_ref = 1'b0, fill_dirty = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        ref_clear = 1'b0, flush = 1'b0;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tlb_fa dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .lk_dirty(lk_dirty), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_ref(fill_ref), .fill_dirty(fill_dirty), .ref_clear(ref_clear), .flush(flush)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_write = 0; fill_en = 0; ref_clear = 0; flush = 0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic r, input logic d, input logic fl);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; fill_ref = r; fill_dirty = d; flush = fl;
    @(posedge clk); #1 idle();
  endtask

  task automatic look(input string req, input logic [19:0] vpn, input logic [11:0] ofs,
                      input logic wr, input logic clr, input logic exp_hit,
                      input logic [19:0] exp_ppn, input logic exp_dty);
    @(negedge clk);
    lk_valid = 1; lk_write = wr; lk_vaddr = {vpn, ofs}; ref_clear = clr;
    #2;
    chk({req, " hit"}, 64'(lk_hit), 64'(exp_hit));
    chk({req, " miss"}, 64'(lk_miss), 64'(!exp_hit));
    chk({req, " paddr"}, 64'(lk_paddr), exp_hit ? 64'({exp_ppn, ofs}) : 64'd0);
    chk({req, " dirty"}, 64'(lk_dirty), 64'(exp_hit && exp_dty));
    @(posedge clk); #1 idle();
  endtask

  task automatic pulse(input logic clr, input logic fl);
    @(negedge clk); ref_clear = clr; flush = fl;
    @(posedge clk); #1 idle();
  endtask

  task automatic t_reset();
    @(negedge clk); #2;
    chk("R2 idle hit", 64'(lk_hit), 0);
    chk("R2 idle miss", 64'(lk_miss), 0);
    look("R10 empty after reset", 20'h12345, 12'h0AB, 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    fill(20'h00010, 20'hABCDE, 0, 0, 0);
    look("R1 R7 read hit", 20'h00010, 12'h123, 0, 0, 1, 20'hABCDE, 0);
    look("R2 other page misses", 20'h00011, 12'h123, 0, 0, 0, 0, 0);
    look("R4 read keeps modify", 20'h00010, 12'hFFF, 0, 0, 1, 20'hABCDE, 0);
    look("R4 write hit", 20'h00010, 12'h001, 1, 0, 1, 20'hABCDE, 0);
    look("R4 modify now set", 20'h00010, 12'h002, 0, 0, 1, 20'hABCDE, 1);
    fill(20'h00020, 20'h55555, 0, 1, 0);
    look("R7 fill modify bit", 20'h00020, 12'h000, 0, 0, 1, 20'h55555, 1);
  endtask

  task automatic t_dup();
    fill(20'h00010, 20'h11111, 0, 0, 0);
    look("R9 overwritten ppn", 20'h00010, 12'h777, 0, 0, 1, 20'h11111, 0);
    look("R9 neighbour kept", 20'h00020, 12'h777, 0, 0, 1, 20'h55555, 1);
  endtask

  task automatic t_flush();
    pulse(0, 1);
    look("R8 flushed a", 20'h00010, 12'h0, 0, 0, 0, 0, 0);
    look("R8 flushed b", 20'h00020, 12'h0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_victim();
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 0, 0, 0);
    look("R6 slot15 filled", 20'h0010F, 12'h0, 0, 0, 1, 20'h0020F, 0);
    look("R3 hit slot0", 20'h00100, 12'h0, 0, 0, 1, 20'h00200, 0);
    // slot15 and slot0 now used; lowest unused slot is 1
    fill(20'h00300, 20'h00400, 0, 0, 0);
    look("R3 R6 slot1 displaced", 20'h00101, 12'h0, 0, 0, 0, 0, 0);
    look("R3 used slot0 kept", 20'h00100, 12'h0, 0, 0, 1, 20'h00200, 0);
    look("R6 new in slot1", 20'h00300, 12'h0, 0, 0, 1, 20'h00400, 0);
    pulse(1, 0);
    fill(20'h00301, 20'h00401, 1, 0, 0);
    look("R5 swept slot0 displaced", 20'h00100, 12'h0, 0, 0, 0, 0, 0);
    look("R5 slot1 kept", 20'h00300, 12'h0, 0, 0, 1, 20'h00400, 0);
    for (int i = 2; i < 16; i++)
      look("R3 mark use", 20'h00100 + 20'(i), 12'h0, 0, 0, 1, 20'h00200 + 20'(i), 0);
    fill(20'h00600, 20'h00700, 0, 0, 0);
    look("R6 all used slot0 taken", 20'h00301, 12'h0, 0, 0, 0, 0, 0);
    look("R6 slot1 survives", 20'h00300, 12'h0, 0, 0, 1, 20'h00400, 0);
    look("R6 new in slot0", 20'h00600, 12'h0, 0, 0, 1, 20'h00700, 0);
  endtask

  task automatic t_prec();
    fill(20'h00800, 20'h00900, 0, 0, 1);
    look("R11 flush beats fill", 20'h00800, 12'h0, 0, 0, 0, 0, 0);
    fill(20'h00A00, 20'h00B00, 0, 0, 0);
    fill(20'h00A01, 20'h00B01, 0, 0, 0);
    for (int i = 2; i < 16; i++) fill(20'h00A00 + 20'(i), 20'h00B00 + 20'(i), 1, 0, 0);
    look("R11 hit with sweep", 20'h00A00, 12'h0, 0, 1, 1, 20'h00B00, 0);
    fill(20'h00AFF, 20'h00BFF, 0, 0, 0);
    look("R11 hit wins over sweep", 20'h00A00, 12'h0, 0, 0, 1, 20'h00B00, 0);
    look("R11 unused slot1 taken", 20'h00A01, 12'h0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_basic();
    t_dup();
    t_flush();
    t_victim();
    t_prec();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule